// File: doc/BRIEF.md
# Descriptor Ring Pointer Manager

This block holds the pointer state for a circular ring of descriptor tables that feeds a receive DMA engine. Software fills tables in host memory and publishes its progress by writing the producer pointer. The hardware side consumes tables in order. The DMA reports each finished entry with a one-cycle pulse, and it can end a table early with a second pulse. The block turns these pulses into a consumer pointer, an entry cursor and a byte offset into the ring. Each entry covers one 4 KB page. Every table holds the same programmed number of entries.

Both pointers are eight bits wide. The seven low bits index a table. Bit 7 is a lap flag, and it inverts each time the index runs past the last table and returns to zero. This lets the block tell a full ring from an empty one without a separate count. The block flags a configuration that is out of range. It holds the DMA back while no filled table is waiting or while the configuration is bad. A parameter builds a variant for a transmit engine, whose ring is always a single table.

Top module: `ring_ptr_mgr`

## Requirements
- R1: After reset, both pointers and the entry cursor are 0, `ring_empty` is 1 and `ring_full` is 0.
- R2: On each table advance, the consumer index goes up by one. When the index would reach the depth, it returns to 0 and bit 7 inverts. With depth 5, the pointer runs 0x00..0x04, then 0x80..0x84, then 0x00.
- R3: An `entry_done` pulse while the engine is active raises `ent_idx` by one. When `ent_idx` equals the entry count minus one, the pulse advances the table and sets `ent_idx` to 0.
- R4: A `table_done` pulse while the engine is active advances the table at once and sets `ent_idx` to 0. It takes priority over an `entry_done` in the same cycle.
- R5: `ring_empty` is 1 exactly when the two pointers are equal. `ring_full` is 1 exactly when the index bits [6:0] match and bit 7 differs.
- R6: The engine is active only when `eng_run` is 1, the configuration is valid and the ring is not empty. `dma_stall` equals `eng_run` AND NOT active. Done pulses have no effect while the engine is not active.
- R7: `cfg_err` is 1 when the depth is 0 or above 128, or when the entry count is 0 or above 256. While it is 1, the pointers and the cursor do not change, except through a clear.
- R8: A write to `sw_wp` is accepted only when the configuration is valid and `sw_wp[6:0]` is less than the depth. Any other write leaves `wr_ptr` unchanged.
- R9: `ptr_clear` sets both pointers and the cursor to 0 only while `eng_run` is 0. While the engine runs, `ptr_clear` is ignored.
- R10: `byte_off` equals (`tbl_idx` × entry count + `ent_idx`) × 4096, where `tbl_idx` is `rd_ptr[6:0]`.
- R11: With `ONE_TABLE` = 1, the depth is forced to 1 and `cfg_depth` is ignored. The consumer pointer then alternates between 0x00 and 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eng_run | input | 1 | Engine enabled |
| cfg_depth | input | 8 | Number of tables in the ring |
| cfg_entries | input | 9 | Entries per table |
| sw_wp_we | input | 1 | Producer pointer write strobe |
| sw_wp | input | 8 | Producer pointer value to write |
| ptr_clear | input | 1 | Clear pointers and cursor (stopped engine only) |
| entry_done | input | 1 | Current entry finished |
| table_done | input | 1 | Current table finished early |
| rd_ptr | output | 8 | Consumer pointer (bit 7 lap flag) |
| wr_ptr | output | 8 | Producer pointer (bit 7 lap flag) |
| ring_empty | output | 1 | No filled table is pending |
| ring_full | output | 1 | Every slot is filled |
| dma_stall | output | 1 | Engine enabled but not ready |
| cfg_err | output | 1 | Depth or entry count out of range |
| tbl_idx | output | 7 | Table index in use |
| ent_idx | output | 8 | Entry index within the table |
| byte_off | output | 28 | Byte offset of the current page in the ring |

## Verification
Some properties are checked on every cycle. Empty and full are never both true. A running engine with an empty ring always stalls. A change of the consumer pointer is always a single step that obeys the lap rule. A bad configuration, a rejected pointer write and a clear issued while the engine runs leave the pointers unchanged. A clear issued while the engine is stopped empties everything. Other behaviour can only be shown by the bench's scenarios. These are the full lap sequence at depth 5 and at depth 128, the entry cursor rolling into the next table, an early table end that overrides an entry pulse, the offset arithmetic at 256 entries, and the single-table variant. A cycle-level reference model is compared against both builds on every clock.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;
    localparam int PTR_W   = 8;
    localparam int IDX_W   = 7;
    localparam int DEPTH_W = 8;

    typedef logic [PTR_W-1:0] ring_ptr_t;

    // Step a pointer by one table; passing the last slot inverts the lap flag
    function automatic ring_ptr_t ptr_advance(ring_ptr_t p, logic [DEPTH_W-1:0] depth);
        logic [DEPTH_W-1:0] nxt;
        nxt = {1'b0, p[IDX_W-1:0]} + DEPTH_W'(1);
        if (nxt >= depth)
            return {~p[PTR_W-1], {IDX_W{1'b0}}};
        else
            return {p[PTR_W-1], nxt[IDX_W-1:0]};
    endfunction
endpackage

// File: rtl/ring_cfg_check.sv
module ring_cfg_check
    import ring_ptr_pkg::*;
#(
    parameter int MAX_TABLES  = 128,
    parameter int MAX_ENTRIES = 256,
    parameter bit ONE_TABLE   = 1'b0,
    localparam int ENT_CNT_W  = $clog2(MAX_ENTRIES) + 1
) (
    input  logic [DEPTH_W-1:0]   cfg_depth,
    input  logic [ENT_CNT_W-1:0] cfg_entries,
    output logic [DEPTH_W-1:0]   depth_eff,
    output logic                 cfg_ok
);
    logic depth_ok;
    logic entries_ok;

    generate
        if (ONE_TABLE) begin : g_single
            assign depth_eff = DEPTH_W'(1);
            assign depth_ok  = 1'b1;
        end else begin : g_ring
            assign depth_eff = cfg_depth;
            assign depth_ok  = (cfg_depth != '0) && (cfg_depth <= DEPTH_W'(MAX_TABLES));
        end
    endgenerate

    assign entries_ok = (cfg_entries != '0) && (cfg_entries <= ENT_CNT_W'(MAX_ENTRIES));
    assign cfg_ok     = depth_ok && entries_ok;
endmodule

// File: rtl/ring_entry_cursor.sv
module ring_entry_cursor #(
    parameter int MAX_ENTRIES = 256,
    localparam int ENT_CNT_W  = $clog2(MAX_ENTRIES) + 1,
    localparam int ENT_IDX_W  = $clog2(MAX_ENTRIES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 active,
    input  logic                 entry_done,
    input  logic                 table_done,
    input  logic [ENT_CNT_W-1:0] entries,
    output logic [ENT_IDX_W-1:0] ent_idx,
    output logic                 tbl_adv
);
    typedef struct packed {
        logic [ENT_IDX_W-1:0] ent;
    } cur_t;

    cur_t cur_d, cur_q;
    logic last_ent;

    always_comb begin
        last_ent = ({1'b0, cur_q.ent} == (entries - ENT_CNT_W'(1)));
        tbl_adv  = active && (table_done || (entry_done && last_ent));
        cur_d    = cur_q;
        if (clear)
            cur_d.ent = '0;
        else if (tbl_adv)
            cur_d.ent = '0;
        else if (active && entry_done)
            cur_d.ent = cur_q.ent + ENT_IDX_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cur_q <= '0;
        else
            cur_q <= cur_d;
    end

    assign ent_idx = cur_q.ent;
endmodule

// File: rtl/ring_offset_calc.sv
module ring_offset_calc
    import ring_ptr_pkg::*;
#(
    parameter int MAX_ENTRIES = 256,
    parameter int PAGE_SHIFT  = 12,
    localparam int ENT_CNT_W  = $clog2(MAX_ENTRIES) + 1,
    localparam int ENT_IDX_W  = $clog2(MAX_ENTRIES),
    localparam int OFF_W      = IDX_W + ENT_CNT_W + PAGE_SHIFT
) (
    input  logic [IDX_W-1:0]     tbl,
    input  logic [ENT_CNT_W-1:0] entries,
    input  logic [ENT_IDX_W-1:0] ent,
    output logic [OFF_W-1:0]     off
);
    logic [OFF_W-1:0] page_num;

    always_comb begin
        page_num = OFF_W'(tbl) * OFF_W'(entries) + OFF_W'(ent);
        off      = page_num << PAGE_SHIFT;
    end
endmodule

// File: rtl/ring_ptr_mgr.sv
module ring_ptr_mgr
    import ring_ptr_pkg::*;
#(
    parameter int MAX_TABLES  = 128,
    parameter int MAX_ENTRIES = 256,
    parameter int PAGE_SHIFT  = 12,
    parameter bit ONE_TABLE   = 1'b0,
    localparam int ENT_CNT_W  = $clog2(MAX_ENTRIES) + 1,
    localparam int ENT_IDX_W  = $clog2(MAX_ENTRIES),
    localparam int OFF_W      = IDX_W + ENT_CNT_W + PAGE_SHIFT
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 eng_run,
    input  logic [DEPTH_W-1:0]   cfg_depth,
    input  logic [ENT_CNT_W-1:0] cfg_entries,
    input  logic                 sw_wp_we,
    input  logic [PTR_W-1:0]     sw_wp,
    input  logic                 ptr_clear,
    input  logic                 entry_done,
    input  logic                 table_done,
    output logic [PTR_W-1:0]     rd_ptr,
    output logic [PTR_W-1:0]     wr_ptr,
    output logic                 ring_empty,
    output logic                 ring_full,
    output logic                 dma_stall,
    output logic                 cfg_err,
    output logic [IDX_W-1:0]     tbl_idx,
    output logic [ENT_IDX_W-1:0] ent_idx,
    output logic [OFF_W-1:0]     byte_off
);
    typedef struct packed {
        ring_ptr_t rd;
        ring_ptr_t wr;
    } ptr_state_t;

    ptr_state_t st_d, st_q;

    logic [DEPTH_W-1:0] depth_eff;
    logic               cfg_ok;
    logic               active;
    logic               clear_ok;
    logic               wp_ok;
    logic               tbl_adv;

    ring_cfg_check #(
        .MAX_TABLES (MAX_TABLES),
        .MAX_ENTRIES(MAX_ENTRIES),
        .ONE_TABLE  (ONE_TABLE)
    ) u_cfg (
        .cfg_depth  (cfg_depth),
        .cfg_entries(cfg_entries),
        .depth_eff  (depth_eff),
        .cfg_ok     (cfg_ok)
    );

    always_comb begin
        ring_empty = (st_q.rd == st_q.wr);
        ring_full  = (st_q.rd[IDX_W-1:0] == st_q.wr[IDX_W-1:0]) &&
                     (st_q.rd[PTR_W-1] != st_q.wr[PTR_W-1]);
        active     = eng_run && cfg_ok && !ring_empty;
        dma_stall  = eng_run && !active;
        clear_ok   = ptr_clear && !eng_run;
        wp_ok      = sw_wp_we && cfg_ok && ({1'b0, sw_wp[IDX_W-1:0]} < depth_eff);
    end

    ring_entry_cursor #(
        .MAX_ENTRIES(MAX_ENTRIES)
    ) u_cursor (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_ok),
        .active    (active),
        .entry_done(entry_done),
        .table_done(table_done),
        .entries   (cfg_entries),
        .ent_idx   (ent_idx),
        .tbl_adv   (tbl_adv)
    );

    always_comb begin
        st_d = st_q;
        if (clear_ok) begin
            st_d.rd = '0;
            st_d.wr = '0;
        end else begin
            if (wp_ok)
                st_d.wr = sw_wp;
            if (tbl_adv)
                st_d.rd = ptr_advance(st_q.rd, depth_eff);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign rd_ptr  = st_q.rd;
    assign wr_ptr  = st_q.wr;
    assign cfg_err = !cfg_ok;
    assign tbl_idx = st_q.rd[IDX_W-1:0];

    ring_offset_calc #(
        .MAX_ENTRIES(MAX_ENTRIES),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_off (
        .tbl    (tbl_idx),
        .entries(cfg_entries),
        .ent    (ent_idx),
        .off    (byte_off)
    );
endmodule

// File: rtl/ring_ptr_mgr_chk.sv
module ring_ptr_mgr_chk #(
    parameter int ENT_CNT_W = 9,
    parameter int ENT_IDX_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 eng_run,
    input logic                 sw_wp_we,
    input logic [7:0]           sw_wp,
    input logic                 ptr_clear,
    input logic [7:0]           rd_ptr,
    input logic [7:0]           wr_ptr,
    input logic                 ring_empty,
    input logic                 ring_full,
    input logic                 dma_stall,
    input logic                 cfg_err,
    input logic [ENT_IDX_W-1:0] ent_idx,
    input logic [7:0]           depth_eff
);
    // R5
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ring_empty && ring_full));

    // R6
    stall_on_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && ring_empty) |-> dma_stall);

    // R2
    rd_single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(rd_ptr) && !$past(ptr_clear)) |->
            ((rd_ptr[6:0] == 7'd0) ? (rd_ptr[7] != $past(rd_ptr[7]))
                                   : ((rd_ptr[7] == $past(rd_ptr[7])) &&
                                      (rd_ptr[6:0] == $past(rd_ptr[6:0]) + 7'd1))));

    // R7
    cfg_err_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !ptr_clear) |=> ($stable(rd_ptr) && $stable(wr_ptr) && $stable(ent_idx)));

    // R8
    wp_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wp_we && !ptr_clear && ({1'b0, sw_wp[6:0]} >= depth_eff)) |=> $stable(wr_ptr));

    // R9
    clear_run_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_run && ptr_clear && !sw_wp_we && dma_stall) |=> ($stable(rd_ptr) && $stable(wr_ptr)));

    // R9
    clear_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!eng_run && ptr_clear) |=> ((rd_ptr == 8'd0) && (wr_ptr == 8'd0) && (ent_idx == '0)));
endmodule

bind ring_ptr_mgr ring_ptr_mgr_chk #(
    .ENT_CNT_W(ENT_CNT_W),
    .ENT_IDX_W(ENT_IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .eng_run   (eng_run),
    .sw_wp_we  (sw_wp_we),
    .sw_wp     (sw_wp),
    .ptr_clear (ptr_clear),
    .rd_ptr    (rd_ptr),
    .wr_ptr    (wr_ptr),
    .ring_empty(ring_empty),
    .ring_full (ring_full),
    .dma_stall (dma_stall),
    .cfg_err   (cfg_err),
    .ent_idx   (ent_idx),
    .depth_eff (depth_eff)
);

// File: tb/ring_ptr_mgr_tb.sv
module ring_ptr_mgr_tb;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       eng_run = 1'b0;
    logic [7:0] cfg_depth = 8'd5;
    logic [8:0] cfg_entries = 9'd3;
    logic       sw_wp_we = 1'b0;
    logic [7:0] sw_wp = 8'd0;
    logic       ptr_clear = 1'b0;
    logic       entry_done = 1'b0;
    logic       table_done = 1'b0;

    logic [7:0]  rd0, wr0, rd1, wr1;
    logic        emp0, full0, stl0, err0, emp1, full1, stl1, err1;
    logic [6:0]  tbl0, tbl1;
    logic [7:0]  ent0, ent1;
    logic [27:0] off0, off1;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ring_ptr_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .eng_run(eng_run), .cfg_depth(cfg_depth),
        .cfg_entries(cfg_entries), .sw_wp_we(sw_wp_we), .sw_wp(sw_wp),
        .ptr_clear(ptr_clear), .entry_done(entry_done), .table_done(table_done),
        .rd_ptr(rd0), .wr_ptr(wr0), .ring_empty(emp0), .ring_full(full0),
        .dma_stall(stl0), .cfg_err(err0), .tbl_idx(tbl0), .ent_idx(ent0),
        .byte_off(off0)
    );

    ring_ptr_mgr #(.ONE_TABLE(1'b1)) u_dut_one (
        .clk(clk), .rst_n(rst_n), .eng_run(eng_run), .cfg_depth(cfg_depth),
        .cfg_entries(cfg_entries), .sw_wp_we(sw_wp_we), .sw_wp(sw_wp),
        .ptr_clear(ptr_clear), .entry_done(entry_done), .table_done(table_done),
        .rd_ptr(rd1), .wr_ptr(wr1), .ring_empty(emp1), .ring_full(full1),
        .dma_stall(stl1), .cfg_err(err1), .tbl_idx(tbl1), .ent_idx(ent1),
        .byte_off(off1)
    );

    // Behavioural reference: index 0 is the ring build, index 1 the single-table build
    int m_rd[2];
    int m_wr[2];
    int m_ent[2];

    function automatic int m_depth(int k);
        return (k == 1) ? 1 : int'(cfg_depth);
    endfunction

    function automatic bit m_ok(int k);
        int d = m_depth(k);
        return (d >= 1) && (d <= 128) && (cfg_entries >= 1) && (cfg_entries <= 256);
    endfunction

    initial begin
        for (int k = 0; k < 2; k++) begin
            m_rd[k] = 0; m_wr[k] = 0; m_ent[k] = 0;
        end
    end

    always @(posedge clk or negedge rst_n) begin
        for (int k = 0; k < 2; k++) begin
            if (!rst_n) begin
                m_rd[k] = 0; m_wr[k] = 0; m_ent[k] = 0;
            end else if (ptr_clear && !eng_run) begin
                m_rd[k] = 0; m_wr[k] = 0; m_ent[k] = 0;
            end else begin
                automatic int  d    = m_depth(k);
                automatic bit  ok   = m_ok(k);
                automatic bit  act  = eng_run && ok && (m_rd[k] != m_wr[k]);
                automatic bit  adv  = act && (table_done ||
                                      (entry_done && (m_ent[k] == int'(cfg_entries) - 1)));
                if (sw_wp_we && ok && (int'(sw_wp[6:0]) < d))
                    m_wr[k] = int'(sw_wp);
                if (adv) begin
                    m_ent[k] = 0;
                    if ((m_rd[k] % 128) + 1 >= d)
                        m_rd[k] = (m_rd[k] & 128) ^ 128;
                    else
                        m_rd[k] = m_rd[k] + 1;
                end else if (act && entry_done) begin
                    m_ent[k] = (m_ent[k] + 1) % 256;
                end
            end
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        for (int k = 0; k < 2; k++) begin
            automatic int  e_rd  = m_rd[k];
            automatic int  e_wr  = m_wr[k];
            automatic bit  e_emp = (e_rd == e_wr);
            automatic bit  e_ful = ((e_rd % 128) == (e_wr % 128)) && (e_rd != e_wr);
            automatic bit  e_ok  = m_ok(k);
            automatic bit  e_stl = eng_run && !(e_ok && !e_emp);
            automatic int  e_off = (((e_rd % 128) * int'(cfg_entries)) + m_ent[k]) * 4096;
            if (k == 0) begin
                chk("R2 rd_ptr", rd0, e_rd);
                chk("R8 wr_ptr", wr0, e_wr);
                chk("R3 ent_idx", ent0, m_ent[k]);
                chk("R5 empty", emp0, e_emp);
                chk("R5 full", full0, e_ful);
                chk("R6 stall", stl0, e_stl);
                chk("R7 cfg_err", err0, !e_ok);
                chk("R10 byte_off", off0, e_off);
            end else begin
                chk("R11 rd_ptr", rd1, e_rd);
                chk("R11 wr_ptr", wr1, e_wr);
                chk("R11 ent_idx", ent1, m_ent[k]);
                chk("R11 empty", emp1, e_emp);
                chk("R11 stall", stl1, e_stl);
                chk("R11 cfg_err", err1, !e_ok);
                chk("R11 byte_off", off1, e_off);
            end
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic quiet();
        sw_wp_we = 0; entry_done = 0; table_done = 0; ptr_clear = 0;
    endtask

    task automatic do_clear();
        eng_run = 0; quiet(); ptr_clear = 1; step(); quiet();
    endtask

    function automatic int lap_seq(int i, int d);
        return ((i / d) % 2) * 128 + (i % d);
    endfunction

    initial begin
        #(200000 * CLK_PERIOD);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 rd_ptr", rd0, 0);
        chk("R1 wr_ptr", wr0, 0);
        chk("R1 empty", emp0, 1);
        chk("R1 full", full0, 0);
        chk("R1 ent_idx", ent0, 0);

        // R2 lap sequence at depth 5, one entry per table
        cfg_depth = 5; cfg_entries = 1;
        sw_wp_we = 1; sw_wp = 8'h80; step();
        chk("R5 full at 0x80", full0, 1);
        eng_run = 1;
        for (int i = 0; i < 11; i++) begin
            entry_done = 1; sw_wp_we = 1; sw_wp = 8'(lap_seq(i + 1, 5) ^ 128);
            step();
            chk("R2 lap seq", rd0, lap_seq(i + 1, 5));
        end
        quiet();

        // R3 entry cursor rolls into next table
        do_clear(); cfg_entries = 3; sw_wp_we = 1; sw_wp = 8'h02; step(); quiet();
        eng_run = 1;
        entry_done = 1; step(); chk("R3 ent 1", ent0, 1);
        step(); chk("R3 ent 2", ent0, 2);
        step(); chk("R3 roll ent", ent0, 0); chk("R3 roll rd", rd0, 1);
        quiet();

        // R4 early table end overrides entry pulse
        entry_done = 1; step(); chk("R4 pre ent", ent0, 1);
        table_done = 1; entry_done = 1; step(); quiet();
        chk("R4 ent cleared", ent0, 0); chk("R4 rd adv", rd0, 2);
        // R6 ring now empty: pulses ignored
        entry_done = 1; step(); quiet();
        chk("R6 empty hold", rd0, 2); chk("R6 stall", stl0, 1);

        // R9 clear ignored while running
        ptr_clear = 1; step(); quiet();
        chk("R9 run clear ignored", rd0, 2);
        do_clear(); chk("R9 idle clear", rd0, 0);

        // R8 out of range write rejected
        sw_wp_we = 1; sw_wp = 8'h05; step(); quiet();
        chk("R8 reject", wr0, 0);

        // R7 bad depth and entry count freeze the engine
        sw_wp_we = 1; sw_wp = 8'h03; step(); quiet();
        eng_run = 1; cfg_depth = 0;
        table_done = 1; step(); quiet();
        chk("R7 depth0 err", err0, 1); chk("R7 depth0 hold", rd0, 0);
        cfg_depth = 200; step(); chk("R7 depth200", err0, 1);
        cfg_depth = 5; cfg_entries = 0; entry_done = 1; step(); quiet();
        chk("R7 entries0", err0, 1); chk("R7 entries0 hold", ent0, 0);
        cfg_entries = 300; step(); chk("R7 entries300", err0, 1);

        // R10 offset with 256 entries and depth 128 laps
        do_clear(); cfg_depth = 128; cfg_entries = 256;
        sw_wp_we = 1; sw_wp = 8'h80; step(); quiet(); eng_run = 1;
        for (int i = 0; i < 127; i++) begin
            table_done = 1; sw_wp_we = 1; sw_wp = 8'(lap_seq(i + 1, 128) ^ 128); step();
        end
        quiet(); chk("R2 idx 127", rd0, 127);
        for (int i = 0; i < 255; i++) begin
            entry_done = 1; step();
        end
        quiet();
        chk("R10 max off", off0, (127 * 256 + 255) * 4096);
        sw_wp_we = 1; sw_wp = 8'h00; entry_done = 1; step(); quiet();
        chk("R2 lap at 128", rd0, 8'h80);

        // Mixed stimulus against the reference model
        do_clear();
        for (int i = 0; i < 3000; i++) begin
            automatic int r = $urandom;
            eng_run    = (r % 8) != 0;
            entry_done = r[3];
            table_done = (r[7:4] == 0);
            sw_wp_we   = r[9:8] == 0;
            sw_wp      = 8'($urandom % 256) & 8'h87;
            ptr_clear  = r[15:10] == 0;
            if (r[23:16] == 0) cfg_depth = 8'($urandom % 10);
            if (r[31:24] == 0) cfg_entries = 9'($urandom % 5);
            step();
        end
        quiet(); step();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule